// File: doc/BRIEF.md
# Dual-Trigger Key Interrupt Generator

This block produces the active-low interrupt request of a key-scanning controller. It watches the occupancy of the key-event queue and the stream of debounced key events. It raises the request when the queue holds enough events, or when a set number of debounce cycles has passed since a key event. Whichever of the two conditions is met first raises the request. A single configuration byte selects both conditions. A clear-mode bit chooses whether the request is withdrawn when the queue drains or when the host reads an entry.

When the configuration byte is all zeros, the interrupt logic is bypassed. The pin then carries a plain general-purpose output bit. The output pin models an open-drain driver: 0 pulls the line low, and 1 releases it. Every decision is registered, so the pin changes at the clock edge that samples the causing inputs.

Top module: `keyirq_gen`

## Requirements
- R1: After reset, `irq_n_o` is 1 (released), and no request is pending.
- R2: While `cfg_i` is 0x00, the next clock edge copies `gpo_bit_i` to `irq_n_o`. Any pending request and any running timer are discarded, so a return to a non-zero configuration starts with no request.
- R3: The level field is `cfg_i[7:5]`. For a field value f other than 0, the threshold is 2*(f+1), clamped to 16: f=1 gives 4, and f=7 gives 16. The value 0 disables the level trigger.
- R4: With the level trigger enabled, when `occupancy_i` is at or above the threshold at a clock edge, `irq_n_o` is 0 after that edge, unless a clear acts in the same cycle.
- R5: The delay field is `cfg_i[4:0]` and holds a value N from 1 to 31. A key event (`key_evt_i`=1) arms the timer when no request is pending. The request asserts at the edge that samples the N-th `dbc_tick_i` after the arming cycle. A tick in the arming cycle is not counted.
- R6: A delay field of 0 disables the timed trigger: key events and ticks alone never assert the request.
- R7: With both triggers enabled, the request asserts at the first edge where either condition holds.
- R8: When `clr_mode_i`=0, a cycle with `q_empty_i`=1 deasserts the request at that edge, and `host_rd_i` has no effect.
- R9: When `clr_mode_i`=1, a cycle with `host_rd_i`=1 deasserts the request at that edge, and `q_empty_i` has no effect.
- R10: A clear takes priority over a trigger in the same cycle. If the level condition still holds, the request reasserts at the following edge.
- R11: Once the request is asserted, the timer stops. Key events seen while the request is pending do not arm it, so after a clear only a new key event restarts the timed trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 8 | Interrupt configuration: [7:5] level field, [4:0] delay field |
| clr_mode_i | input | 1 | 0: clear on queue empty, 1: clear on host read |
| dbc_tick_i | input | 1 | One-cycle pulse per debounce cycle |
| key_evt_i | input | 1 | One-cycle pulse per debounced key event |
| occupancy_i | input | 5 | Number of events held in the queue (0..16) |
| q_empty_i | input | 1 | Queue is empty |
| host_rd_i | input | 1 | One-cycle pulse when the host reads the queue |
| gpo_bit_i | input | 1 | Output level used when the configuration is 0x00 |
| irq_n_o | output | 1 | Active-low request, 1 = released |

## Verification
The bench builds the block with its default parameters: a 5-bit delay field, a 3-bit level field, a 5-bit occupancy and a ceiling of 16. With these values the clamped threshold of 16 can be reached at field value 7, and a delay of several ticks can be counted. Single-cycle pulses of tick, key event and host read are placed cycle by cycle. This exercises the race between the two triggers, a clear and a trigger in the same cycle, and key events that land while a request is pending.

// File: rtl/keyirq_pkg.sv
package keyirq_pkg;
  typedef enum logic {
    CLR_ON_EMPTY = 1'b0,
    CLR_ON_READ  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/keyirq_level.sv
module keyirq_level #(
  parameter int SEL_W   = 3,
  parameter int OCC_W   = 5,
  parameter int LVL_MAX = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic             hit_o
);
  localparam int THR_W = OCC_W + 2;

  logic [THR_W-1:0] raw_thr;
  logic [THR_W-1:0] thr;

  // threshold = 2*(field+1), clamped to LVL_MAX
  always_comb begin
    raw_thr = THR_W'((int'(sel_i) + 1) * 2);
    thr     = (raw_thr > THR_W'(LVL_MAX)) ? THR_W'(LVL_MAX) : raw_thr;
    hit_o   = (sel_i != '0) && ({2'b00, occ_i} >= thr);
  end
endmodule

// File: rtl/keyirq_timer.sv
module keyirq_timer #(
  parameter int TSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic              tick_i,
  input  logic              key_evt_i,
  input  logic              bypass_i,
  input  logic              req_q_i,
  input  logic              req_next_i,
  output logic              fire_o
);
  logic              armed_q;
  logic [TSEL_W-1:0] cnt_q;
  logic [TSEL_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    fire_o  = armed_q && tick_i && (tsel_i != '0) && (cnt_inc >= {1'b0, tsel_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (bypass_i || (tsel_i == '0) || fire_o || req_next_i) begin
      armed_q <= 1'b0;
    end else if (!armed_q && key_evt_i && !req_q_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_inc[TSEL_W-1:0];
    end
  end

  // R11: an asserting request stops the timer
  p_disarm_on_req_r11: assert property (@(posedge clk) disable iff (rst)
    req_next_i |=> !armed_q);

  // R5: the count advances only on debounce ticks
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !tick_i && !req_next_i && !bypass_i && tsel_i != '0) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/keyirq_gen.sv
module keyirq_gen
  import keyirq_pkg::*;
#(
  parameter int TSEL_W  = 5,
  parameter int QSEL_W  = 3,
  parameter int OCC_W   = 5,
  parameter int LVL_MAX = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TSEL_W+QSEL_W-1:0] cfg_i,
  input  logic                     clr_mode_i,
  input  logic                     dbc_tick_i,
  input  logic                     key_evt_i,
  input  logic [OCC_W-1:0]         occupancy_i,
  input  logic                     q_empty_i,
  input  logic                     host_rd_i,
  input  logic                     gpo_bit_i,
  output logic                     irq_n_o
);
  localparam int CFG_W = TSEL_W + QSEL_W;

  logic [TSEL_W-1:0] tsel;
  logic [QSEL_W-1:0] qsel;
  logic              bypass;
  logic              lvl_hit;
  logic              t_fire;
  logic              clr_now;
  logic              pend_q;
  logic              pend_d;
  logic              irq_n_q;
  clr_mode_e         cmode;

  assign tsel   = cfg_i[TSEL_W-1:0];
  assign qsel   = cfg_i[CFG_W-1:TSEL_W];
  assign bypass = (cfg_i == '0);
  assign cmode  = clr_mode_e'(clr_mode_i);

  keyirq_level #(
    .SEL_W  (QSEL_W),
    .OCC_W  (OCC_W),
    .LVL_MAX(LVL_MAX)
  ) u_level (
    .sel_i(qsel),
    .occ_i(occupancy_i),
    .hit_o(lvl_hit)
  );

  keyirq_timer #(
    .TSEL_W(TSEL_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tsel_i    (tsel),
    .tick_i    (dbc_tick_i),
    .key_evt_i (key_evt_i),
    .bypass_i  (bypass),
    .req_q_i   (pend_q),
    .req_next_i(pend_d),
    .fire_o    (t_fire)
  );

  always_comb begin
    clr_now = (cmode == CLR_ON_READ) ? host_rd_i : q_empty_i;
    if (bypass || clr_now) pend_d = 1'b0;
    else                   pend_d = pend_q || lvl_hit || t_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      irq_n_q <= bypass ? gpo_bit_i : ~pend_d;
    end
  end

  assign irq_n_o = irq_n_q;

  // R2: general-purpose output pass-through
  p_gpo_follow_r2: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (irq_n_o == $past(gpo_bit_i)));

  // R4: level condition pulls the line low
  p_level_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!bypass && lvl_hit && !clr_now) |=> !irq_n_o);

  // R8: empty queue releases the line in clear mode 0
  p_clear_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !clr_mode_i && q_empty_i) |=> irq_n_o);

  // R9: host read releases the line in clear mode 1
  p_clear_read_r9: assert property (@(posedge clk) disable iff (rst)
    (!bypass && clr_mode_i && host_rd_i) |=> irq_n_o);
endmodule

// File: tb/keyirq_gen_tb.sv
module keyirq_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg = 8'h00;
  logic       cmode = 1'b0;
  logic       tick = 1'b0;
  logic       evt = 1'b0;
  logic [4:0] occ = 5'd0;
  logic       qe = 1'b1;
  logic       rd = 1'b0;
  logic       gpo = 1'b1;
  logic       irq_n;

  logic [7:0] n_cfg = 8'h00;
  logic       n_mode = 1'b0;
  logic       n_gpo = 1'b1;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  keyirq_gen u_dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_i      (cfg),
    .clr_mode_i (cmode),
    .dbc_tick_i (tick),
    .key_evt_i  (evt),
    .occupancy_i(occ),
    .q_empty_i  (qe),
    .host_rd_i  (rd),
    .gpo_bit_i  (gpo),
    .irq_n_o    (irq_n)
  );

  // driver: one call per cycle, pushes the expected pin value after the next edge
  task automatic cyc(input logic tk, input logic ev, input logic hr,
                     input int o, input logic exp, input string tag);
    @(negedge clk);
    cfg = n_cfg; cmode = n_mode; gpo = n_gpo;
    tick = tk; evt = ev; rd = hr;
    occ = 5'(o); qe = (o == 0);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_n !== e) begin
        failures++;
        $display("FAIL %s irq_n actual=%b expected=%b", t, irq_n, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, bypass with gpo high
    cyc(0,0,0,0,1'b1,"R1");
    // R2 pass-through
    n_gpo = 1'b0; cyc(0,0,0,0,1'b0,"R2 gpo low");
    n_gpo = 1'b1; cyc(0,0,0,0,1'b1,"R2 gpo high");
    // R3/R4 level trigger, field 1 -> threshold 4, clear mode 0
    n_cfg = 8'b001_00000; n_mode = 1'b0;
    cyc(0,0,0,3,1'b1,"R4 below threshold");
    cyc(0,0,0,4,1'b0,"R3 threshold 4 reached");
    cyc(0,0,0,5,1'b0,"R4 held");
    // R8 host read ignored in mode 0, empty clears
    cyc(0,0,1,1,1'b0,"R8 read ignored");
    cyc(0,0,0,0,1'b1,"R8 empty clears");
    // R3 clamp: field 7 -> 16
    n_cfg = 8'b111_00000;
    cyc(0,0,0,15,1'b1,"R3 15 below 16");
    cyc(0,0,0,16,1'b0,"R3 clamp 16");
    cyc(0,0,0,0,1'b1,"R8 empty clears again");
    // R5 timed trigger, N=3, clear mode 1
    n_cfg = 8'b000_00011; n_mode = 1'b1;
    cyc(1,1,0,1,1'b1,"R5 arm, tick not counted");
    cyc(1,0,0,1,1'b1,"R5 tick1");
    cyc(1,0,0,1,1'b1,"R5 tick2");
    cyc(0,0,0,1,1'b1,"R5 idle");
    cyc(1,0,0,1,1'b0,"R5 tick3 fires");
    // R11 events while pending do not arm
    cyc(0,1,0,1,1'b0,"R11 event while pending");
    cyc(1,0,0,1,1'b0,"R11 pending held");
    // R9 empty ignored in mode 1, read clears
    cyc(0,0,0,0,1'b0,"R9 empty ignored");
    cyc(0,0,1,1,1'b1,"R9 read clears");
    cyc(1,0,0,1,1'b1,"R11 no rearm tick1");
    cyc(1,0,0,1,1'b1,"R11 no rearm tick2");
    cyc(1,0,0,1,1'b1,"R11 no rearm tick3");
    cyc(1,0,0,1,1'b1,"R11 no rearm tick4");
    // R6 delay field 0
    n_cfg = 8'b001_00000;
    cyc(0,1,0,1,1'b1,"R6 event");
    for (int i = 0; i < 5; i++) cyc(1,0,0,1,1'b1,"R6 tick");
    // R7 both enabled: level first, threshold 4, N=5
    n_cfg = 8'b001_00101;
    cyc(0,1,0,1,1'b1,"R7 arm");
    cyc(1,0,0,1,1'b1,"R7 tick1");
    cyc(0,0,0,4,1'b0,"R7 level first");
    // R10 clear beats trigger, then reassert
    cyc(0,0,1,4,1'b1,"R10 clear wins");
    cyc(0,0,0,4,1'b0,"R10 reassert");
    cyc(0,0,1,1,1'b1,"R10 clear below level");
    // R7 timer first
    cyc(0,1,0,1,1'b1,"R7 rearm");
    for (int i = 0; i < 4; i++) cyc(1,0,0,1,1'b1,"R7 count");
    cyc(1,0,0,1,1'b0,"R7 timer first");
    // R2 bypass discards pending
    n_cfg = 8'h00; n_gpo = 1'b1;
    cyc(0,0,0,1,1'b1,"R2 bypass over pending");
    n_cfg = 8'b001_00101;
    cyc(0,0,0,1,1'b1,"R2 pending discarded");
    cyc(1,0,0,1,1'b1,"R2 timer discarded");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule